// File: doc/BRIEF.md
# Iterative Sine/Cosine Rotation Engine

The block turns a two's-complement angle into its sine and cosine with a sequential shift-and-add rotation that uses no multiplier. One pair of add/subtract units per coordinate is reused over a fixed number of clock cycles. In each cycle the three running values (X, Y and the residual angle Z) pass through barrel shifters and a small arctangent table, and both are indexed by an iteration counter. The reciprocal of the rotation gain is preloaded into the starting X value, so the finished vector already has unit length.

A caller places an angle on `angle_i` and raises `load_i` for one cycle. The input multiplexers then take the fresh starting vector in place of the fed-back registers. Angles beyond a quarter turn are first turned through half a revolution, and both results are negated at the end. After the last iteration `done_o` pulses for one cycle, and the results stay on the outputs until the next computation finishes. A separate active-low input clears only the iteration counter. The synchronous active-low `rst_n` clears the whole unit.

Top module: `cordic_sincos`

## Requirements
- R1: While `rst_n` is low at a rising edge, the unit clears itself: after that edge `sin_o` and `cos_o` read 0, `done_o` is 0, and no result from a computation started before the reset is ever reported.
- R2: A rising edge with `load_i` high captures `angle_i` and starts a new computation. Any computation in progress is dropped, and only the most recently loaded angle produces a `done_o` pulse.
- R3: With `iter_rst_n` held high, `done_o` goes high exactly ITER rising edges after the edge that sampled `load_i`, and it stays high for exactly one cycle.
- R4: The angle is signed, with 2^(ANG_W-1) meaning half a revolution. Results are signed with 2^(DATA_W-2) meaning 1.0. For angles in [-π/2, π/2) the results are within 4 LSB of the true sine and cosine. Each iteration rotates in the direction that moves the residual angle toward zero.
- R5: Angles outside [-π/2, π/2), including -π and the largest positive code, also give sine and cosine within 4 LSB. This comes from a half-turn pre-rotation and a final sign flip.
- R6: `sin_o` and `cos_o` change only on the edge that raises `done_o`. They hold their values while idle and while a later computation is still running.
- R7: With no computation running, holding `iter_rst_n` low changes neither output and raises no `done_o`.
- R8: While a computation runs, an edge with `iter_rst_n` low performs no rotation and sends the iteration index back to 0. `done_o` then comes ITER edges after the last such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the whole unit |
| iter_rst_n | input | 1 | Synchronous active-low clear of the iteration counter only |
| load_i | input | 1 | Selects a fresh start vector in place of the fed-back registers |
| angle_i | input | ANG_W | Signed angle, 2^(ANG_W-1) = π |
| sin_o | output | DATA_W | Signed sine, 2^(DATA_W-2) = 1.0 |
| cos_o | output | DATA_W | Signed cosine, 2^(DATA_W-2) = 1.0 |
| done_o | output | 1 | One-cycle pulse when new results appear |

## Verification
The embedded properties check several things on every cycle. The residual angle must move monotonically in the direction set by its sign. `done_o` must never last longer than a cycle. The outputs must stay frozen outside a `done_o` edge. A counter clear must never coincide with a completion, and an idle controller must stay idle unless loaded. Numerical accuracy against true sine and cosine, correct handling of the pre-rotated quadrants, and the exact completion timing after loads, counter clears and mid-run resets are shown only by the bench's scenarios and its behavioural reference model.

// File: rtl/cordic_pkg.sv
// Shared definitions for the iterative rotation engine.
// Assumes: the angle word plus guard bits is at most 31 bits wide.
package cordic_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Elementary angles atan(2^-idx), scaled so that 2^32 is one full turn.
    function automatic logic [31:0] atan_turn32(input int idx);
        case (idx)
            0:  return 32'h2000_0000;
            1:  return 32'h12E4_051E;
            2:  return 32'h09FB_385B;
            3:  return 32'h0511_11D4;
            4:  return 32'h028B_0D43;
            5:  return 32'h0145_D7E1;
            6:  return 32'h00A2_F61E;
            7:  return 32'h0051_7C55;
            8:  return 32'h0028_BE53;
            9:  return 32'h0014_5F2F;
            10: return 32'h000A_2F98;
            11: return 32'h0005_17CC;
            12: return 32'h0002_8BE6;
            13: return 32'h0001_45F3;
            14: return 32'h0000_A2FA;
            15: return 32'h0000_517D;
            16: return 32'h0000_28BE;
            17: return 32'h0000_145F;
            18: return 32'h0000_0A30;
            19: return 32'h0000_0518;
            20: return 32'h0000_028C;
            21: return 32'h0000_0146;
            22: return 32'h0000_00A3;
            23: return 32'h0000_0051;
            24: return 32'h0000_0029;
            25: return 32'h0000_0014;
            26: return 32'h0000_000A;
            27: return 32'h0000_0005;
            28: return 32'h0000_0003;
            29: return 32'h0000_0001;
            30: return 32'h0000_0001;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Rescale a table entry to a word of width w (2^w = one turn), rounded to nearest.
    function automatic logic [31:0] atan_scaled(input int idx, input int w);
        logic [32:0] t;
        t = {1'b0, atan_turn32(idx)} + (33'd1 << (31 - w));
        return 32'(t >> (32 - w));
    endfunction

endpackage

// File: rtl/cordic_barrel_shift.sv
// Logarithmic arithmetic right shifter.
// Assumes: amount is an unsigned iteration index; the sign is replicated.
module cordic_barrel_shift #(
    parameter int W    = 20,
    parameter int SH_W = 4
) (
    input  logic signed [W-1:0]    data_i,
    input  logic        [SH_W-1:0] amt_i,
    output logic signed [W-1:0]    data_o
);
    logic signed [W-1:0] stage [SH_W+1];

    assign stage[0] = data_i;

    // One stage per amount bit, each shifting by a power of two.
    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        assign stage[g+1] = amt_i[g] ? (stage[g] >>> (1 << g)) : stage[g];
    end

    assign data_o = stage[SH_W];
endmodule

// File: rtl/cordic_atan_rom.sv
// Elementary-angle lookup, one entry per iteration, built from the package table.
// Assumes: ITER <= 32 and ZW <= 31; ITER is a power of two so every index is valid.
module cordic_atan_rom #(
    parameter int ITER  = 16,
    parameter int ZW    = 20,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]   idx_i,
    output logic signed [ZW-1:0] atan_o
);
    logic signed [ZW-1:0] rom [ITER];

    // Fill each entry with a constant computed at elaboration.
    for (genvar g = 0; g < ITER; g++) begin : g_entry
        assign rom[g] = ZW'(cordic_pkg::atan_scaled(g, ZW));
    end

    assign atan_o = rom[idx_i];
endmodule

// File: rtl/cordic_iter_ctrl.sv
// Iteration sequencer: run/idle state plus the index counter with its own clear.
// Assumes: load has priority; a counter clear while running suppresses that cycle's step.
module cordic_iter_ctrl
    import cordic_pkg::*;
#(
    parameter int ITER  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iter_rst_n,
    input  logic             load_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             step_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ITER - 1);

    run_state_e       state_q;
    logic [IDX_W-1:0] cnt_q;

    // Sequence the state and the iteration index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (load_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else if (!iter_rst_n) begin
            cnt_q   <= '0;
        end else if (state_q == ST_RUN) begin
            if (cnt_q == LAST_IDX) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Decode the rotate strobe and the final-step strobe.
    always_comb begin
        step_o = (state_q == ST_RUN) && iter_rst_n && !load_i;
        last_o = step_o && (cnt_q == LAST_IDX);
    end

    assign idx_o = cnt_q;

    assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_q == ST_RUN) && (cnt_q == '0));

    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !load_i |=> (state_q == ST_IDLE) && (cnt_q == '0));
endmodule

// File: rtl/cordic_sincos.sv
// Iterative circular-rotation sine/cosine engine.
// Assumes: angle 2^(ANG_W-1) = pi; results 2^(DATA_W-2) = 1.0; ITER a power of two <= 32.
module cordic_sincos #(
    parameter int DATA_W  = 16,
    parameter int ANG_W   = 16,
    parameter int ITER    = 16,
    parameter int GUARD   = 4,
    parameter int Z_GUARD = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iter_rst_n,
    input  logic                     load_i,
    input  logic [ANG_W-1:0]         angle_i,
    output logic signed [DATA_W-1:0] sin_o,
    output logic signed [DATA_W-1:0] cos_o,
    output logic                     done_o
);
    localparam int IW    = DATA_W + GUARD;
    localparam int FRAC  = DATA_W - 2 + GUARD;
    localparam int ZW    = ANG_W + Z_GUARD;
    localparam int IDX_W = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic signed [IW-1:0] X_INIT   = IW'($rtoi(0.6072529350088813 * (2.0 ** FRAC) + 0.5));
    localparam logic signed [IW-1:0] RND_HALF = IW'(1) <<< (GUARD - 1);

    logic [IDX_W-1:0]     idx;
    logic                 step, last_step;
    logic signed [IW-1:0] x_q, y_q, x_sh, y_sh, x_n, y_n;
    logic signed [ZW-1:0] z_q, z_n, z_start, atan_v;
    logic                 flip, neg_q;
    logic signed [IW-1:0] cos_rnd, sin_rnd;

    cordic_iter_ctrl #(.ITER(ITER), .IDX_W(IDX_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .iter_rst_n (iter_rst_n),
        .load_i     (load_i),
        .idx_o      (idx),
        .step_o     (step),
        .last_o     (last_step)
    );

    cordic_atan_rom #(.ITER(ITER), .ZW(ZW), .IDX_W(IDX_W)) i_rom (
        .idx_i  (idx),
        .atan_o (atan_v)
    );

    cordic_barrel_shift #(.W(IW), .SH_W(IDX_W)) i_shx (
        .data_i (x_q),
        .amt_i  (idx),
        .data_o (x_sh)
    );

    cordic_barrel_shift #(.W(IW), .SH_W(IDX_W)) i_shy (
        .data_i (y_q),
        .amt_i  (idx),
        .data_o (y_sh)
    );

    // Fold angles outside the half-plane by a half turn (invert the sign bit).
    always_comb begin
        flip    = angle_i[ANG_W-1] ^ angle_i[ANG_W-2];
        z_start = {(angle_i[ANG_W-1] ^ flip), angle_i[ANG_W-2:0], {Z_GUARD{1'b0}}};
    end

    // One micro-rotation; a negative residual angle rotates clockwise.
    always_comb begin
        if (z_q[ZW-1]) begin
            x_n = x_q + y_sh;
            y_n = y_q - x_sh;
            z_n = z_q + atan_v;
        end else begin
            x_n = x_q - y_sh;
            y_n = y_q + x_sh;
            z_n = z_q - atan_v;
        end
    end

    // Input multiplexers: fresh start vector on load, feedback on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            z_q   <= '0;
            neg_q <= 1'b0;
        end else if (load_i) begin
            x_q   <= X_INIT;
            y_q   <= '0;
            z_q   <= z_start;
            neg_q <= flip;
        end else if (step) begin
            x_q <= x_n;
            y_q <= y_n;
            z_q <= z_n;
        end
    end

    // Undo the pre-rotation and round away the guard bits.
    always_comb begin
        cos_rnd = (neg_q ? -x_n : x_n) + RND_HALF;
        sin_rnd = (neg_q ? -y_n : y_n) + RND_HALF;
    end

    // Capture results and raise done on the last micro-rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_o  <= '0;
            sin_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last_step;
            if (last_step) begin
                cos_o <= DATA_W'(cos_rnd >>> GUARD);
                sin_o <= DATA_W'(sin_rnd >>> GUARD);
            end
        end
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o && $past(rst_n) |-> $stable(sin_o) && $stable(cos_o));

    assert_dir_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step && !z_q[ZW-1] |=> $signed(z_q) <= $signed($past(z_q)));

    assert_dir_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step && z_q[ZW-1] |=> $signed(z_q) >= $signed($past(z_q)));

    assert_clear_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !iter_rst_n && !load_i |=> !done_o);
endmodule

// File: tb/test_cordic_sincos.sv
module test_cordic_sincos;
    localparam int  CLK_PERIOD = 10;
    localparam int  DATA_W     = 16;
    localparam int  ANG_W      = 16;
    localparam int  ITER       = 16;
    localparam int  TOL        = 4;
    localparam real PI         = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iter_rst_n = 1'b1;
    logic load = 1'b0;
    logic [ANG_W-1:0] angle = '0;
    logic signed [DATA_W-1:0] sin_o, cos_o;
    logic done_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cordic_sincos #(.DATA_W(DATA_W), .ANG_W(ANG_W), .ITER(ITER)) i_cordic_sincos (
        .clk        (clk),
        .rst_n      (rst_n),
        .iter_rst_n (iter_rst_n),
        .load_i     (load),
        .angle_i    (angle),
        .sin_o      (sin_o),
        .cos_o      (cos_o),
        .done_o     (done_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string ctx = "R1";
    bit    running_checks = 1'b0;
    bit    finished = 1'b0;

    function automatic int ref_val(input logic [ANG_W-1:0] a, input bit want_sin);
        real th, v;
        th = real'($signed(a)) * PI / real'(1 << (ANG_W - 1));
        v  = want_sin ? $sin(th) : $cos(th);
        v  = v * (2.0 ** (DATA_W - 2));
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input string req, input int act, input int exp, input int tol);
        n_cmp++;
        if (act - exp > tol || exp - act > tol) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Behavioural reference: remaining edges, pending and held results.
    int m_rem = 0;
    bit m_done = 1'b0;
    int m_sin = 0, m_cos = 0, p_sin = 0, p_cos = 0;
    bit p_exact = 1'b1, m_exact = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_done = 1'b0; m_sin = 0; m_cos = 0; m_exact = 1'b1;
        end else if (load) begin
            m_rem = ITER; m_done = 1'b0; p_exact = 1'b1;
            p_sin = ref_val(angle, 1'b1);
            p_cos = ref_val(angle, 1'b0);
        end else if (m_rem > 0) begin
            if (!iter_rst_n) begin
                m_rem = ITER; m_done = 1'b0; p_exact = 1'b0;
            end else begin
                m_rem--;
                m_done = (m_rem == 0);
                if (m_done) begin
                    m_sin = p_sin; m_cos = p_cos; m_exact = p_exact;
                end
            end
        end else begin
            m_done = 1'b0;
        end
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (running_checks && !finished) begin
            check({ctx, "/R3 done"}, int'(done_o), int'(m_done), 0);
            if (m_exact) begin
                check({ctx, " sin"}, int'(sin_o), m_sin, TOL);
                check({ctx, " cos"}, int'(cos_o), m_cos, TOL);
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic start_angle(input int a);
        @(negedge clk);
        angle = ANG_W'(a);
        load  = 1'b1;
        @(negedge clk);
        load  = 1'b0;
    endtask

    // Load an angle and check done at the exact edge and the values it presents.
    task automatic run_angle(input string req, input int a);
        start_angle(a);
        repeat (ITER - 1) @(negedge clk);
        check({req, " done early"}, int'(done_o), 0, 0);
        @(negedge clk);
        check({req, " R3 done edge"}, int'(done_o), 1, 0);
        check({req, " sin"}, int'(sin_o), ref_val(ANG_W'(a), 1'b1), TOL);
        check({req, " cos"}, int'(cos_o), ref_val(ANG_W'(a), 1'b0), TOL);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int hold_s, hold_c;
        @(posedge clk);
        running_checks = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sin", int'(sin_o), 0, 0);
        check("R1 cos", int'(cos_o), 0, 0);
        check("R1 done", int'(done_o), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        ctx = "R4";
        run_angle("R4", 0);
        run_angle("R4", 5461);
        run_angle("R4", -8192);
        run_angle("R4", 10923);
        run_angle("R4", 16383);
        run_angle("R4", -16384);
        run_angle("R4", 1);

        ctx = "R5";
        run_angle("R5", 24576);
        run_angle("R5", -24576);
        run_angle("R5", -32768);
        run_angle("R5", 32767);
        run_angle("R5", 21845);
        run_angle("R5", 16384);

        // R6: outputs hold while the next computation runs
        ctx = "R6";
        hold_s = int'(sin_o);
        hold_c = int'(cos_o);
        start_angle(-5000);
        repeat (8) @(negedge clk);
        check("R6 sin held", int'(sin_o), hold_s, 0);
        check("R6 cos held", int'(cos_o), hold_c, 0);
        repeat (ITER) @(negedge clk);
        check("R6 new sin", int'(sin_o), ref_val(ANG_W'(-5000), 1'b1), TOL);

        // R7: counter clear while idle has no effect
        ctx = "R7";
        hold_s = int'(sin_o);
        hold_c = int'(cos_o);
        iter_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        iter_rst_n = 1'b1;
        check("R7 sin", int'(sin_o), hold_s, 0);
        check("R7 cos", int'(cos_o), hold_c, 0);
        check("R7 done", int'(done_o), 0, 0);
        run_angle("R7", 3000);

        // R8: counter clear mid-run restarts the index and delays done
        ctx = "R8";
        start_angle(7000);
        repeat (4) @(negedge clk);
        iter_rst_n = 1'b0;
        @(negedge clk);
        iter_rst_n = 1'b1;
        repeat (ITER - 1) @(negedge clk);
        check("R8 no done yet", int'(done_o), 0, 0);
        @(negedge clk);
        check("R8 done after clear", int'(done_o), 1, 0);
        @(negedge clk);

        // R2: a new load during a run replaces it
        ctx = "R2";
        start_angle(12000);
        repeat (5) @(negedge clk);
        run_angle("R2", -20000);

        // R1: reset in the middle of a run
        ctx = "R1";
        start_angle(9000);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 sin mid-run", int'(sin_o), 0, 0);
        check("R1 cos mid-run", int'(cos_o), 0, 0);
        repeat (ITER + 2) @(negedge clk);
        check("R1 no stale done", int'(done_o), 0, 0);
        check("R1 sin stays", int'(sin_o), 0, 0);
        run_angle("R1", -1234);

        finish_run();
    end
endmodule